// File: doc/BRIEF.md
# Bitstream Decimation Filter

This block turns the one-bit output of a first-order sigma-delta modulator into signed multi-bit samples at a lower rate. Each accepted input bit is mapped to +1 or -1. The mapped value then passes through a chain of running-sum stages that work at the input rate. A chain of first-difference stages follows, and it is clocked only once per decimation period. The default is two stages of each kind, which gives a second-order sinc low-pass response.

The decimation ratio is a runtime value. It is latched when a start pulse arrives, and it sets both the output rate and the resolution: a larger ratio gives a bigger output range and a slower stream of samples. The running sums are allowed to wrap. The accumulator width is the stage count times the log2 of the largest ratio, plus two bits, so the differences always recover the true value. After every start, the filter holds back its first incomplete output. Every sample it emits therefore covers a full window.

Top module: `sdd_decimator`

## Requirements
- R1: After reset, `sample_valid` is low and `sample_out` is zero.
- R2: Before the first `start` pulse, the block produces no output pulse, whatever `bit_in` and `bit_valid` do.
- R3: An input bit of 1 counts as +1 and a bit of 0 counts as -1. A steady stream of ones gives +R*R and a steady stream of zeros gives -R*R, where R is the effective ratio.
- R4: Number the accepted bits after a start from 0, and call the k-th emitted sample (k from 0) y_k. Each y_k equals the sum, over t and s in 0..R-1, of the mapped value of bit k*R+1+t+s.
- R5: One sample is emitted per R accepted bits, and `sample_valid` is high for exactly one cycle each time.
- R6: The first decimated result after a start is discarded. The first pulse follows the 2R-th accepted bit, and `start` itself never produces a pulse in the next cycle.
- R7: `ratio` is sampled only on `start`. Changing it while the filter runs has no effect on output timing or values.
- R8: A `ratio` below 2 acts as 2. A `ratio` above 2^OSR_LOG2_MAX acts as 2^OSR_LOG2_MAX.
- R9: Cycles where `bit_valid` is low are skipped and do not change any result. A bit presented in the same cycle as `start` is not accepted.
- R10: Outputs stay correct over arbitrarily long runs, even though the running sums wrap.
- R11: `sample_valid` goes high in the cycle right after the clock edge that accepts the R-th bit of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears the filter, latches `ratio` and starts running |
| ratio | input | OSR_LOG2_MAX+1 | Requested decimation ratio |
| bit_in | input | 1 | Modulator bit |
| bit_valid | input | 1 | Qualifies `bit_in` |
| sample_out | output | ORDER*OSR_LOG2_MAX+2 | Signed decimated sample |
| sample_valid | output | 1 | One-cycle strobe for `sample_out` |

## Verification
The bench drives long all-ones runs at the largest ratio, so the running sums wrap many times. A design whose width or wrap handling is wrong would emit values other than R*R there. It sends ratios of 1 and 100 to expose a clamp that is missing or off by one, which would show up as a wrong pulse spacing and a wrong value. It also changes `ratio` in the middle of a run, which catches a design that tracks the live input instead of the latched value. Finally, it restarts a running filter and checks pulse timing after every bit. A design that kept stale difference state, or that emitted its first incomplete window, would pulse after R bits instead of 2R and would give a value outside the model.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

    typedef enum logic {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    typedef struct packed {
        logic run;
        logic accept;
        logic tick;
        logic clr;
    } rate_ctrl_t;

    function automatic int acc_bits(input int order, input int lg);
        return order * lg + 2;
    endfunction

    function automatic int ratio_bits(input int lg);
        return lg + 1;
    endfunction

endpackage

// File: rtl/sdd_rate_ctrl.sv
module sdd_rate_ctrl
    import sdd_pkg::*;
#(
    parameter int LG = 12,
    parameter int RW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [RW-1:0] ratio_in,
    input  logic          bit_valid,
    output rate_ctrl_t    ctrl
);
    localparam logic [RW-1:0] R_MIN = RW'(2);
    localparam logic [RW-1:0] R_MAX = RW'(1) << LG;

    run_state_e    st_q;
    logic [RW-1:0] ratio_q;
    logic [RW-1:0] ratio_eff;
    logic [RW-1:0] cnt_q;
    logic          last;

    always_comb begin
        if (ratio_in < R_MIN)      ratio_eff = R_MIN;
        else if (ratio_in > R_MAX) ratio_eff = R_MAX;
        else                       ratio_eff = ratio_in;
    end

    always_comb begin
        ctrl.run    = (st_q == RUN_ACTIVE);
        ctrl.clr    = start;
        ctrl.accept = ctrl.run && bit_valid && !start;
        last        = (cnt_q == ratio_q - RW'(1));
        ctrl.tick   = ctrl.accept && last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= RUN_IDLE;
            ratio_q <= R_MIN;
            cnt_q   <= '0;
        end else if (start) begin
            st_q    <= RUN_ACTIVE;
            ratio_q <= ratio_eff;
            cnt_q   <= '0;
        end else if (ctrl.accept) begin
            cnt_q <= last ? '0 : cnt_q + RW'(1);
        end
    end

    // R5: the period counter never reaches the latched ratio
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        ctrl.run |-> (cnt_q < ratio_q));

    // R7: the latched ratio moves only on start
    a_r7_ratio_hold: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && !start) |=> $stable(ratio_q));

    // R8: the effective ratio stays inside the clamp range
    a_r8_ratio_range: assert property (@(posedge clk) disable iff (rst)
        ctrl.run |-> (ratio_q >= R_MIN && ratio_q <= R_MAX));

endmodule

// File: rtl/sdd_integ.sv
module sdd_integ #(
    parameter int ORDER = 2,
    parameter int W     = 26
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] sum_next
);
    logic [W-1:0] acc_q [ORDER];
    logic [W-1:0] nxt   [ORDER];
    logic [W-1:0] x_pm;

    // +1 for a one, -1 (all ones in two's complement) for a zero
    assign x_pm = bit_in ? W'(1) : '1;

    for (genvar k = 0; k < ORDER; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign nxt[k] = acc_q[k] + x_pm;
        end else begin : g_rest
            assign nxt[k] = acc_q[k] + nxt[k-1];
        end

        always_ff @(posedge clk) begin
            if (rst || clr)
                acc_q[k] <= '0;
            else if (en)
                acc_q[k] <= nxt[k];
        end
    end

    assign sum_next = nxt[ORDER-1];

endmodule

// File: rtl/sdd_comb.sv
module sdd_comb #(
    parameter int ORDER = 2,
    parameter int W     = 26
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                en,
    input  logic [W-1:0]        din,
    output logic signed [W-1:0] dout,
    output logic                dvalid
);
    localparam int DW = $clog2(ORDER) + 1;

    logic [W-1:0]  d      [ORDER+1];
    logic [W-1:0]  prev_q [ORDER];
    logic [DW-1:0] dcnt_q;
    logic          primed;

    assign d[0]   = din;
    assign primed = (dcnt_q == DW'(ORDER - 1));

    for (genvar k = 0; k < ORDER; k++) begin : g_diff
        assign d[k+1] = d[k] - prev_q[k];

        always_ff @(posedge clk) begin
            if (rst || clr)
                prev_q[k] <= '0;
            else if (en)
                prev_q[k] <= d[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            dcnt_q <= '0;
            dvalid <= 1'b0;
            dout   <= '0;
        end else begin
            dvalid <= 1'b0;
            if (en) begin
                if (primed) begin
                    dvalid <= 1'b1;
                    dout   <= $signed(d[ORDER]);
                end else begin
                    dcnt_q <= dcnt_q + DW'(1);
                end
            end
        end
    end

    // R6: a sample is emitted only once the warm-up results are discarded
    a_r6_primed_before_out: assert property (@(posedge clk) disable iff (rst)
        dvalid |-> (dcnt_q == DW'(ORDER - 1)));

endmodule

// File: rtl/sdd_decimator.sv
module sdd_decimator
    import sdd_pkg::*;
#(
    parameter int OSR_LOG2_MAX = 12,
    parameter int ORDER        = 2,
    localparam int RW = ratio_bits(OSR_LOG2_MAX),
    localparam int W  = acc_bits(ORDER, OSR_LOG2_MAX)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [RW-1:0]       ratio,
    input  logic                bit_in,
    input  logic                bit_valid,
    output logic signed [W-1:0] sample_out,
    output logic                sample_valid
);
    rate_ctrl_t   ctrl;
    logic [W-1:0] integ_sum;

    sdd_rate_ctrl #(.LG(OSR_LOG2_MAX), .RW(RW)) u_rate (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ratio_in  (ratio),
        .bit_valid (bit_valid),
        .ctrl      (ctrl)
    );

    sdd_integ #(.ORDER(ORDER), .W(W)) u_integ (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctrl.clr),
        .en       (ctrl.accept),
        .bit_in   (bit_in),
        .sum_next (integ_sum)
    );

    sdd_comb #(.ORDER(ORDER), .W(W)) u_comb (
        .clk    (clk),
        .rst    (rst),
        .clr    (ctrl.clr),
        .en     (ctrl.tick),
        .din    (integ_sum),
        .dout   (sample_out),
        .dvalid (sample_valid)
    );

    // R2: no output before the first start
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |-> !sample_valid);

    // R5: the output strobe lasts a single cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    // R6: a start is never followed by an output in the next cycle
    a_r6_start_quiet: assert property (@(posedge clk) disable iff (rst)
        start |=> !sample_valid);

endmodule

// File: tb/tb_sdd_decimator.sv
module tb_sdd_decimator;
    localparam int CLK_P = 10;
    localparam int LG    = 6;
    localparam int ORD   = 2;
    localparam int RW    = LG + 1;
    localparam int W     = ORD * LG + 2;

    typedef struct packed {
        int r_in;
        int r_eff;
        int pat;
        int expv;
    } vec_t;

    // pat: 0 ones, 1 zeros, 2 alternating, 3 three ones then a zero
    localparam vec_t VEC [8] = '{
        '{16, 16, 0,  256},
        '{16, 16, 1, -256},
        '{16, 16, 2,    0},
        '{ 8,  8, 3,   32},
        '{12, 12, 3,   72},
        '{64, 64, 0, 4096},
        '{100, 64, 0, 4096},
        '{ 1,  2, 0,    4}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [RW-1:0] ratio;
    logic          bit_in;
    logic          bit_valid;
    logic signed [W-1:0] sample_out;
    logic          sample_valid;

    int n_chk  = 0;
    int n_fail = 0;
    int ocnt;
    int obuf [64];
    bit got_pulse;
    int timing_bad;
    bit sb [2048];
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_P/2) clk = ~clk;

    sdd_decimator #(.OSR_LOG2_MAX(LG), .ORDER(ORD)) dut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .ratio        (ratio),
        .bit_in       (bit_in),
        .bit_valid    (bit_valid),
        .sample_out   (sample_out),
        .sample_valid (sample_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
        got_pulse = sample_valid;
        if (sample_valid) begin
            if (ocnt < 64) obuf[ocnt] = int'(sample_out);
            ocnt++;
        end
    endtask

    task automatic fill(input int pat, input int n);
        for (int i = 0; i < n; i++) begin
            case (pat)
                0: sb[i] = 1'b1;
                1: sb[i] = 1'b0;
                2: sb[i] = (i % 2 == 0);
                3: sb[i] = (i % 4 != 3);
                default: begin
                    lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    sb[i] = lfsr[0];
                end
            endcase
        end
    endtask

    function automatic int model(input int k, input int r);
        int acc = 0;
        for (int t = 0; t < r; t++)
            for (int s = 0; s < r; s++)
                acc += sb[k*r + 1 + t + s] ? 1 : -1;
        return acc;
    endfunction

    // start with r_in, feed n bits with 'gap' idle cycles after each,
    // optionally change the ratio input at bit chg_at
    task automatic run_stream(input int r_in, input int r_eff, input int n,
                              input int gap, input int chg_at, input int chg_val);
        step();
        start = 1'b1; ratio = RW'(r_in); bit_valid = 1'b0;
        step();
        start = 1'b0;
        ocnt = 0; timing_bad = 0;
        for (int i = 0; i < n; i++) begin
            if (i == chg_at) ratio = RW'(chg_val);
            bit_in = sb[i]; bit_valid = 1'b1;
            step();
            if (got_pulse != (((i + 1) % r_eff == 0) && (i + 1 >= 2 * r_eff)))
                timing_bad++;
            bit_valid = 1'b0; bit_in = ~bit_in;
            for (int g = 0; g < gap; g++) begin
                step();
                if (got_pulse) timing_bad++;
            end
        end
        bit_valid = 1'b0;
        step();
        if (got_pulse) timing_bad++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; ratio = '0; bit_in = 1'b0; bit_valid = 1'b0;
        ocnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        chk(sample_valid == 1'b0, "R1 valid after reset", int'(sample_valid), 0);
        chk(sample_out == '0, "R1 output after reset", int'(sample_out), 0);

        // R2: bits before any start
        ocnt = 0;
        for (int i = 0; i < 40; i++) begin
            bit_in = i[0]; bit_valid = 1'b1;
            step();
        end
        bit_valid = 1'b0;
        step();
        chk(ocnt == 0, "R2 pulses before start", ocnt, 0);

        // table walk: R3 values, R8 clamp, R5/R6/R11 timing
        for (int v = 0; v < 8; v++) begin
            fill(VEC[v].pat, 4 * VEC[v].r_eff);
            run_stream(VEC[v].r_in, VEC[v].r_eff, 4 * VEC[v].r_eff, 0, -1, 0);
            chk(ocnt == 3, "R5/R8 output count", ocnt, 3);
            chk(timing_bad == 0, "R6/R11 pulse timing", timing_bad, 0);
            for (int k = 0; k < 3; k++)
                chk(obuf[k] == VEC[v].expv, "R3/R8 table value", obuf[k], VEC[v].expv);
        end

        // R10: long all-ones run, sums wrap many times
        fill(0, 64 * 22);
        run_stream(64, 64, 64 * 22, 0, -1, 0);
        chk(ocnt == 21, "R10 long run count", ocnt, 21);
        for (int k = 0; k < 21; k++)
            chk(obuf[k] == 4096, "R10 wrapped value", obuf[k], 4096);

        // R4: pseudo-random stream against the window model
        fill(4, 100);
        run_stream(10, 10, 100, 0, -1, 0);
        chk(ocnt == 9, "R4 random count", ocnt, 9);
        chk(timing_bad == 0, "R11 random timing", timing_bad, 0);
        for (int k = 0; k < 9; k++)
            chk(obuf[k] == model(k, 10), "R4 random value", obuf[k], model(k, 10));

        // R9: idle cycles between valid bits
        fill(4, 64);
        run_stream(8, 8, 64, 2, -1, 0);
        chk(ocnt == 7, "R9 gapped count", ocnt, 7);
        chk(timing_bad == 0, "R9 gapped timing", timing_bad, 0);
        for (int k = 0; k < 7; k++)
            chk(obuf[k] == model(k, 8), "R9 gapped value", obuf[k], model(k, 8));

        // R7: ratio input changed mid-run
        fill(0, 48);
        run_stream(8, 8, 48, 0, 20, 16);
        chk(ocnt == 5, "R7 count after ratio change", ocnt, 5);
        chk(timing_bad == 0, "R7 timing after ratio change", timing_bad, 0);
        for (int k = 0; k < 5; k++)
            chk(obuf[k] == 64, "R7 value after ratio change", obuf[k], 64);

        // R6: restart while running discards stale state and first result
        fill(4, 12);
        run_stream(4, 4, 12, 0, -1, 0);
        chk(ocnt == 2, "R6 restart count", ocnt, 2);
        chk(timing_bad == 0, "R6 restart timing", timing_bad, 0);
        for (int k = 0; k < 2; k++)
            chk(obuf[k] == model(k, 4), "R6 restart value", obuf[k], model(k, 4));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule